// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the programmable state of an interrupt distributor for up to eight processors. Line numbers 0 to 31 are private: each processor has its own copy of their enable, pending and priority state and reaches it through the same addresses. Lines 32 and above are global. For each global line the bank also stores a trigger mode and exactly one target processor. Software reaches the bank over a simple register bus. Each access carries the requesting processor's id and is a byte, halfword or word access.

From the enable, pending and target state the bank derives one flag per processor. A flag says that the processor has at least one interrupt it could take. Downstream logic uses this flag to wake the processor or to start delivery. Choosing among the pending lines and delivering them to a processor lie outside this block.

Byte offsets, with words little-endian: 0x000 control (bit 0 is the global enable), 0x004 type, 0x080 group, 0x100 set-enable, 0x140 clear-enable, 0x180 set-pending, 0x1C0 clear-pending, 0x200 and 0x240 active set/clear, 0x400 priority (one byte per line), 0x600 targets (one byte per line), 0x800 trigger view (two bits per line). In each bit register, word 0 is the private lines and word n covers lines 32n to 32n+31.

Top module: `irq_dist_regs`

## Requirements
- R1: A write to set-enable or set-pending ORs the written ones into the state. A write to the matching clear register removes them. Both addresses of a pair read back the same current state.
- R2: After reset the global enable is 0, nothing is pending and every line is disabled except lines 0 to 15. Those lines always read as enabled, and a clear-enable write cannot disable them.
- R3: Enable, pending and priority state of lines 0 to 31 is kept separately for each processor id. An access only sees and changes the copy of the requesting processor.
- R4: The trigger view holds two bits per line: bit 2k+1 of a word is 1 for edge and 0 for level, and bit 2k always reads 0. The words for lines 0 to 31 always read 0xAAAAAAAA and ignore writes. Global lines reset to level.
- R5: A targets write selects, for each written byte, the lowest set bit as the single target processor. An all-zero byte selects processor 0. A read returns a byte with only the stored target's bit set.
- R6: The targets words for lines 0 to 31 are read-only. Every byte reads as a mask with only the requesting processor's bit set.
- R7: The type word reads (processors − 1) in bits 7:5 and (lines / 32) − 1 in bits 4:0. Writes to it are ignored.
- R8: The group and active set/clear regions read zero, and writes to them change no state.
- R9: The flag of processor c is set when one of its private lines is both pending and enabled. It is also set when a global line is pending, enabled and targeted at c. The flag follows one clock after the write that changes the state.
- R10: While the global enable is 0, the flag vector is exactly 1 for processor 0 and 0 for the others. This holds from reset onward.
- R11: Size 0 is a byte and size 1 a halfword. Write data sits in the low bits of the data bus and is moved up by 8 × address bits 1:0. Only the accessed byte lanes change. Read data comes back shifted down in the same way, with the bits above the access size zero.
- R12: An address outside every region above, or beyond the configured number of lines, reads zero and changes no state.
- R13: Priority bytes are stored and read back as written, for the private lines of each processor and for the global lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regValid | input | 1 | Access valid this cycle; read data is combinational |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address |
| regSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| regCpu | input | 3 | Requesting processor id; private state of ids ≥ NUM_CPUS reads zero |
| regWdata | input | 32 | Write data, right-aligned |
| regRdata | output | 32 | Read data, right-aligned |
| cpuPending | output | NUM_CPUS | Registered per-processor pending flag |

## Verification
A wrong stored bit shows up in the very next read of its own address, and the set/clear pair pins down which of the two paths damaged it. A corrupted target index or enable bit shows up in the flag vector one clock after the write, and it raises the wrong processor's flag rather than none. So the bench sweeps every global line through every target. It also reads each private word back under several processor ids, so that a banking slip, which lets one processor's write appear in another's copy, is caught at once.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_RAZ, RG_SETEN, RG_CLREN,
    RG_SETPD, RG_CLRPD, RG_PRIO, RG_TGT, RG_CFG
  } regionE;

  typedef enum logic [1:0] {WK_NONE, WK_SET, WK_CLR, WK_VAL} writeKindE;

  typedef struct packed {
    regionE      region;
    logic [6:0]  wordIdx;
    logic [3:0]  laneMask;
    logic [4:0]  shift;
    logic [31:0] readMask;
    logic [31:0] wdataAligned;
    writeKindE   writeKind;
  } busStrobeT;

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [11:0] regAddr,
  input  logic [1:0]  regSize,
  input  logic [31:0] regWdata,
  output busStrobeT   strb
);
  localparam int NWORDS = NUM_LINES / 32;

  regionE     region;
  logic [6:0] wIdx;

  always_comb begin
    region = RG_NONE;
    wIdx   = '0;
    if (regValid) begin
      if (regAddr[11:2] == 10'd0) begin
        region = RG_CTRL;
      end else if (regAddr[11:2] == 10'd1) begin
        region = RG_TYPE;
      end else if (regAddr[11:9] == 3'd2) begin
        if (int'(regAddr[8:2]) < NUM_LINES / 4) region = RG_PRIO;
        wIdx = regAddr[8:2];
      end else if (regAddr[11:9] == 3'd3) begin
        if (int'(regAddr[8:2]) < NUM_LINES / 4) region = RG_TGT;
        wIdx = regAddr[8:2];
      end else if (regAddr[11:7] == 5'h10) begin
        if (int'(regAddr[6:2]) < NUM_LINES / 16) region = RG_CFG;
        wIdx = {2'b00, regAddr[6:2]};
      end else begin
        wIdx = {3'b000, regAddr[5:2]};
        case (regAddr[11:6])
          6'd2, 6'd8, 6'd9: region = RG_RAZ;
          6'd4:             region = RG_SETEN;
          6'd5:             region = RG_CLREN;
          6'd6:             region = RG_SETPD;
          6'd7:             region = RG_CLRPD;
          default:          region = RG_NONE;
        endcase
        if (region inside {RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD} &&
            int'(regAddr[5:2]) >= NWORDS)
          region = RG_NONE;
      end
    end
  end

  always_comb begin
    strb.region       = region;
    strb.wordIdx      = wIdx;
    strb.shift        = {regAddr[1:0], 3'b000};
    strb.wdataAligned = regWdata << strb.shift;
    case (regSize)
      2'd0: begin
        strb.laneMask = 4'b0001 << regAddr[1:0];
        strb.readMask = 32'h0000_00FF;
      end
      2'd1: begin
        strb.laneMask = 4'b0011 << {regAddr[1], 1'b0};
        strb.readMask = 32'h0000_FFFF;
      end
      default: begin
        strb.laneMask = 4'b1111;
        strb.readMask = 32'hFFFF_FFFF;
      end
    endcase
    strb.writeKind = WK_NONE;
    if (regWrite) begin
      case (region)
        RG_SETEN, RG_SETPD:               strb.writeKind = WK_SET;
        RG_CLREN, RG_CLRPD:               strb.writeKind = WK_CLR;
        RG_CTRL, RG_PRIO, RG_TGT, RG_CFG: strb.writeKind = WK_VAL;
        default:                          strb.writeKind = WK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobeT                  strb,
  input  logic [2:0]                 regCpu,
  output logic [31:0]                regRdata,
  output logic                       globalEn,
  output logic [NUM_CPUS*32-1:0]     bankEnFlat,
  output logic [NUM_CPUS*32-1:0]     bankPendFlat,
  output logic [NUM_LINES-33:0]      shEnOut,
  output logic [NUM_LINES-33:0]      shPendOut,
  output logic [(NUM_LINES-32)*3-1:0] shTgtFlat
);
  localparam int NSH    = NUM_LINES - 32;
  localparam int NSW    = NSH / 32;
  localparam int NSPW   = NSH / 4;
  localparam int NSCW   = NSH / 16;
  localparam logic [31:0] TYPE_VAL =
      (32'(NUM_CPUS - 1) << 5) | 32'(NUM_LINES / 32 - 1);

  logic            ctrlEn;
  logic [31:0]     bankEn   [NUM_CPUS];
  logic [31:0]     bankPend [NUM_CPUS];
  logic [7:0]      bankPri  [NUM_CPUS][32];
  logic [NSH-1:0]  shEn, shPend, shCfg;
  logic [7:0]      shPri [NSH];
  logic [2:0]      shTgt [NSH];

  logic [31:0] curWord, newWord, laneBits, wdMasked;
  logic [7:0]  selfMask;
  int          w;

  function automatic logic [2:0] lowestIdx(input logic [7:0] b);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) if (b[i]) r = 3'(i);
    return r;
  endfunction

  assign w        = int'(strb.wordIdx);
  assign selfMask = 8'd1 << regCpu;
  assign laneBits = {{8{strb.laneMask[3]}}, {8{strb.laneMask[2]}},
                     {8{strb.laneMask[1]}}, {8{strb.laneMask[0]}}};
  assign wdMasked = strb.wdataAligned & laneBits;

  // Current word at the decoded address; feeds both reads and merges.
  always_comb begin
    curWord = '0;
    case (strb.region)
      RG_CTRL: curWord = {31'b0, ctrlEn};
      RG_TYPE: curWord = TYPE_VAL;
      RG_SETEN, RG_CLREN: begin
        for (int c = 0; c < NUM_CPUS; c++)
          if (w == 0 && int'(regCpu) == c) curWord = bankEn[c];
        for (int k = 0; k < NSW; k++)
          if (w == k + 1) curWord = shEn[32*k +: 32];
      end
      RG_SETPD, RG_CLRPD: begin
        for (int c = 0; c < NUM_CPUS; c++)
          if (w == 0 && int'(regCpu) == c) curWord = bankPend[c];
        for (int k = 0; k < NSW; k++)
          if (w == k + 1) curWord = shPend[32*k +: 32];
      end
      RG_PRIO: begin
        for (int c = 0; c < NUM_CPUS; c++)
          for (int k = 0; k < 8; k++)
            if (w == k && int'(regCpu) == c)
              curWord = {bankPri[c][4*k+3], bankPri[c][4*k+2],
                         bankPri[c][4*k+1], bankPri[c][4*k]};
        for (int k = 0; k < NSPW; k++)
          if (w == k + 8)
            curWord = {shPri[4*k+3], shPri[4*k+2], shPri[4*k+1], shPri[4*k]};
      end
      RG_TGT: begin
        if (w < 8) curWord = {4{selfMask}};
        for (int k = 0; k < NSPW; k++)
          if (w == k + 8)
            for (int j = 0; j < 4; j++)
              curWord[8*j +: 8] = 8'd1 << shTgt[4*k+j];
      end
      RG_CFG: begin
        if (w < 2) curWord = 32'hAAAA_AAAA;
        for (int k = 0; k < NSCW; k++)
          if (w == k + 2)
            for (int j = 0; j < 16; j++)
              curWord[2*j+1] = shCfg[16*k+j];
      end
      default: curWord = '0;
    endcase
  end

  always_comb begin
    case (strb.writeKind)
      WK_SET:  newWord = curWord | wdMasked;
      WK_CLR:  newWord = curWord & ~wdMasked;
      WK_VAL:  newWord = (curWord & ~laneBits) | wdMasked;
      default: newWord = curWord;
    endcase
  end

  assign regRdata = (curWord >> strb.shift) & strb.readMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0;
      shEn   <= '0;
      shPend <= '0;
      shCfg  <= '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        bankEn[c]   <= 32'h0000_FFFF;
        bankPend[c] <= '0;
        for (int i = 0; i < 32; i++) bankPri[c][i] <= '0;
      end
      for (int i = 0; i < NSH; i++) begin
        shPri[i] <= '0;
        shTgt[i] <= '0;
      end
    end else if (strb.writeKind != WK_NONE) begin
      case (strb.region)
        RG_CTRL: ctrlEn <= newWord[0];
        RG_SETEN, RG_CLREN: begin
          for (int c = 0; c < NUM_CPUS; c++)
            if (w == 0 && int'(regCpu) == c) bankEn[c] <= newWord | 32'h0000_FFFF;
          for (int k = 0; k < NSW; k++)
            if (w == k + 1) shEn[32*k +: 32] <= newWord;
        end
        RG_SETPD, RG_CLRPD: begin
          for (int c = 0; c < NUM_CPUS; c++)
            if (w == 0 && int'(regCpu) == c) bankPend[c] <= newWord;
          for (int k = 0; k < NSW; k++)
            if (w == k + 1) shPend[32*k +: 32] <= newWord;
        end
        RG_PRIO: begin
          for (int c = 0; c < NUM_CPUS; c++)
            for (int k = 0; k < 8; k++)
              if (w == k && int'(regCpu) == c)
                for (int j = 0; j < 4; j++) bankPri[c][4*k+j] <= newWord[8*j +: 8];
          for (int k = 0; k < NSPW; k++)
            if (w == k + 8)
              for (int j = 0; j < 4; j++) shPri[4*k+j] <= newWord[8*j +: 8];
        end
        RG_TGT: begin
          for (int k = 0; k < NSPW; k++)
            if (w == k + 8)
              for (int j = 0; j < 4; j++) shTgt[4*k+j] <= lowestIdx(newWord[8*j +: 8]);
        end
        RG_CFG: begin
          for (int k = 0; k < NSCW; k++)
            if (w == k + 2)
              for (int j = 0; j < 16; j++) shCfg[16*k+j] <= newWord[2*j+1];
        end
        default: ;
      endcase
    end
  end

  assign globalEn  = ctrlEn;
  assign shEnOut   = shEn;
  assign shPendOut = shPend;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bankFlat
    assign bankEnFlat[32*c +: 32]   = bankEn[c];
    assign bankPendFlat[32*c +: 32] = bankPend[c];
  end
  for (genvar i = 0; i < NSH; i++) begin : g_tgtFlat
    assign shTgtFlat[3*i +: 3] = shTgt[i];
  end

endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        globalEn,
  input  logic [NUM_CPUS*32-1:0]      bankEnFlat,
  input  logic [NUM_CPUS*32-1:0]      bankPendFlat,
  input  logic [NUM_LINES-33:0]       shEn,
  input  logic [NUM_LINES-33:0]       shPend,
  input  logic [(NUM_LINES-32)*3-1:0] shTgtFlat,
  output logic [NUM_CPUS-1:0]         cpuPending
);
  localparam int NSH = NUM_LINES - 32;

  logic [NUM_CPUS-1:0] anyPend;
  logic [NSH-1:0]      shLive;

  assign shLive = shPend & shEn;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NSH-1:0] tgtHit;
    for (genvar i = 0; i < NSH; i++) begin : g_line
      assign tgtHit[i] = (shTgtFlat[3*i +: 3] == 3'(c));
    end
    assign anyPend[c] = (|(bankPendFlat[32*c +: 32] & bankEnFlat[32*c +: 32])) |
                        (|(shLive & tgtHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cpuPending <= NUM_CPUS'(1);
    else if (globalEn) cpuPending <= anyPend;
    else               cpuPending <= NUM_CPUS'(1);
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regValid,
  input  logic                regWrite,
  input  logic [11:0]         regAddr,
  input  logic [1:0]          regSize,
  input  logic [2:0]          regCpu,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [NUM_CPUS-1:0] cpuPending
);
  localparam int NSH = NUM_LINES - 32;

  busStrobeT                  strb;
  logic                       globalEn;
  logic [NUM_CPUS*32-1:0]     bankEnFlat, bankPendFlat;
  logic [NSH-1:0]             shEn, shPend;
  logic [NSH*3-1:0]           shTgtFlat;

  irq_dist_decode #(.NUM_LINES(NUM_LINES)) u_decode (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regSize  (regSize),
    .regWdata (regWdata),
    .strb     (strb)
  );

  irq_dist_state #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_state (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regCpu       (regCpu),
    .regRdata     (regRdata),
    .globalEn     (globalEn),
    .bankEnFlat   (bankEnFlat),
    .bankPendFlat (bankPendFlat),
    .shEnOut      (shEn),
    .shPendOut    (shPend),
    .shTgtFlat    (shTgtFlat)
  );

  irq_dist_pend #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_pend (
    .clk          (clk),
    .rstN         (rstN),
    .globalEn     (globalEn),
    .bankEnFlat   (bankEnFlat),
    .bankPendFlat (bankPendFlat),
    .shEn         (shEn),
    .shPend       (shPend),
    .shTgtFlat    (shTgtFlat),
    .cpuPending   (cpuPending)
  );

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                regValid,
  input logic                regWrite,
  input logic [11:0]         regAddr,
  input logic [1:0]          regSize,
  input logic [2:0]          regCpu,
  input logic [31:0]         regRdata,
  input logic [NUM_CPUS-1:0] cpuPending,
  input logic                globalEn
);
  localparam logic [31:0] TYPE_EXP =
      (32'(NUM_CPUS - 1) << 5) | 32'(NUM_LINES / 32 - 1);

  logic rdWord;
  assign rdWord = regValid && !regWrite && regSize[1] && regAddr[1:0] == 2'b00;

  // R10: disabled distributor flags processor 0 alone
  a_r10_disabled_cpu0: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> cpuPending == NUM_CPUS'(1));

  // R7: type word content
  a_r7_type_value: assert property (@(posedge clk) disable iff (!rstN)
    rdWord && regAddr == 12'h004 |-> regRdata == TYPE_EXP);

  // R8: group and active regions read zero
  a_r8_raz_read: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regWrite && regAddr[11:6] inside {6'd2, 6'd8, 6'd9} |-> regRdata == 32'd0);

  // R2: software lines 0-15 always read enabled
  a_r2_sgi_enabled: assert property (@(posedge clk) disable iff (!rstN)
    rdWord && regCpu < 3'(NUM_CPUS) && (regAddr == 12'h100 || regAddr == 12'h140)
    |-> regRdata[15:0] == 16'hFFFF);

  // R4: lower bit of each trigger field reads zero
  a_r4_cfg_lowbit: assert property (@(posedge clk) disable iff (!rstN)
    rdWord && regAddr[11:7] == 5'h10 |-> (regRdata & 32'h5555_5555) == 32'd0);

  // R6: private target words show the requester's bit in every byte
  a_r6_banked_tgt: assert property (@(posedge clk) disable iff (!rstN)
    rdWord && regAddr[11:5] == 7'h30 |-> regRdata == {4{8'd1 << regCpu}});

  // R5: every global target byte names exactly one processor
  a_r5_tgt_onehot: assert property (@(posedge clk) disable iff (!rstN)
    rdWord && regAddr[11:9] == 3'd3 && int'(regAddr[8:2]) < NUM_LINES / 4
    |-> $countones(regRdata[7:0]) == 1 && $countones(regRdata[15:8]) == 1 &&
        $countones(regRdata[23:16]) == 1 && $countones(regRdata[31:24]) == 1);

  // R12: addresses above the trigger view read zero
  a_r12_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regWrite && regAddr[11] && regAddr[10:7] != 4'd0 |-> regRdata == 32'd0);

endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regValid   (regValid),
  .regWrite   (regWrite),
  .regAddr    (regAddr),
  .regSize    (regSize),
  .regCpu     (regCpu),
  .regRdata   (regRdata),
  .cpuPending (cpuPending),
  .globalEn   (globalEn)
);

// File: tb/irq_dist_regs_bench.sv
`timescale 1ns/1ps
module irq_dist_regs_bench;
  localparam int NCPU = 4;
  localparam int NLIN = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regValid = 1'b0;
  logic             regWrite = 1'b0;
  logic [11:0]      regAddr = '0;
  logic [1:0]       regSize = 2'd2;
  logic [2:0]       regCpu = '0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic [NCPU-1:0]  cpuPending;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  irq_dist_regs #(.NUM_CPUS(NCPU), .NUM_LINES(NLIN)) u_irq_dist_regs (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regSize(regSize), .regCpu(regCpu),
    .regWdata(regWdata), .regRdata(regRdata), .cpuPending(cpuPending)
  );

  task automatic checkEq(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] cpu, input logic [11:0] addr,
                          input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regCpu = cpu;
    regAddr = addr; regSize = sz; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic expectRead(input string req, input logic [2:0] cpu, input logic [11:0] addr,
                            input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regCpu = cpu; regAddr = addr; regSize = sz;
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
    checkEq(req, d, exp);
  endtask

  task automatic expectPend(input string req, input logic [31:0] exp);
    @(negedge clk);
    checkEq(req, 32'(cpuPending), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] model;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    expectPend("R10 reset flags", 32'h1);
    expectRead("R2 reset ctrl", 0, 12'h000, 2, 32'h0);
    expectRead("R2 reset private enables", 0, 12'h100, 2, 32'h0000FFFF);
    expectRead("R2 reset global enables", 0, 12'h104, 2, 32'h0);
    expectRead("R7 type", 0, 12'h004, 2, 32'h61);

    // R2 / R3: software lines survive clear, private copies independent
    busWrite(1, 12'h140, 2, 32'hFFFFFFFF);
    expectRead("R2 clear-enable on sw lines", 1, 12'h100, 2, 32'h0000FFFF);
    busWrite(1, 12'h100, 2, 32'h00030000);
    expectRead("R3 cpu1 private enable", 1, 12'h140, 2, 32'h0003FFFF);
    expectRead("R3 cpu0 untouched", 0, 12'h100, 2, 32'h0000FFFF);

    // R1: sweep global enables bit by bit
    model = '0;
    for (int i = 0; i < 32; i++) begin
      busWrite(0, 12'h104, 2, 32'd1 << i);
      model |= 32'd1 << i;
      if (i % 8 == 7) begin
        expectRead("R1 set-enable read", 0, 12'h104, 2, model);
        expectRead("R1 clear-enable read", 2, 12'h144, 2, model);
      end
    end
    busWrite(0, 12'h144, 2, 32'h55555555);
    expectRead("R1 clear-enable removes", 0, 12'h104, 2, 32'hAAAAAAAA);

    busWrite(0, 12'h184, 2, 32'h0F0F0000);
    expectRead("R1 set-pending", 0, 12'h1C4, 2, 32'h0F0F0000);
    busWrite(0, 12'h1C4, 2, 32'h0F000000);
    expectRead("R1 clear-pending", 0, 12'h184, 2, 32'h000F0000);
    busWrite(0, 12'h1C4, 2, 32'hFFFFFFFF);

    // R4 trigger view
    expectRead("R4 private view", 0, 12'h800, 2, 32'hAAAAAAAA);
    busWrite(0, 12'h804, 2, 32'h0);
    expectRead("R4 private ignores write", 0, 12'h804, 2, 32'hAAAAAAAA);
    busWrite(0, 12'h808, 2, 32'h80000003);
    expectRead("R4 global edge bits", 0, 12'h808, 2, 32'h80000002);
    expectRead("R4 global reset level", 0, 12'h80C, 2, 32'h0);

    // R5 targets narrowing
    busWrite(0, 12'h620, 2, 32'h000C0006);
    expectRead("R5 narrow and zero byte", 0, 12'h620, 2, 32'h01040102);
    busWrite(0, 12'h624, 2, 32'h000080F0);
    expectRead("R5 lowest bit", 0, 12'h624, 2, 32'h01018010);

    // R6 private targets
    expectRead("R6 cpu2 view", 2, 12'h600, 2, 32'h04040404);
    busWrite(2, 12'h604, 2, 32'h0);
    expectRead("R6 cpu3 view", 3, 12'h604, 2, 32'h08080808);
    expectRead("R6 cpu2 after write", 2, 12'h604, 2, 32'h04040404);

    // R8 / R7 ignored writes
    busWrite(0, 12'h080, 2, 32'hFFFFFFFF);
    expectRead("R8 group", 0, 12'h080, 2, 32'h0);
    busWrite(0, 12'h204, 2, 32'hFFFFFFFF);
    expectRead("R8 active set", 0, 12'h204, 2, 32'h0);
    expectRead("R8 pending untouched", 0, 12'h184, 2, 32'h0);
    busWrite(0, 12'h004, 2, 32'h0);
    expectRead("R7 type after write", 0, 12'h004, 2, 32'h61);

    // R13 / R11 priority lanes
    busWrite(0, 12'h401, 0, 32'h5A);
    expectRead("R13 byte into word", 0, 12'h400, 2, 32'h00005A00);
    expectRead("R11 byte read", 0, 12'h401, 0, 32'h5A);
    busWrite(0, 12'h402, 1, 32'hBEEF);
    expectRead("R11 halfword write", 0, 12'h400, 2, 32'hBEEF5A00);
    expectRead("R11 halfword read", 0, 12'h402, 1, 32'hBEEF);
    expectRead("R3 cpu1 priority", 1, 12'h400, 2, 32'h0);
    busWrite(0, 12'h420, 2, 32'h11223344);
    busWrite(0, 12'h423, 0, 32'h99);
    expectRead("R13 global priority", 3, 12'h420, 2, 32'h99223344);

    // R11 sub-word set-enable; data above the lane dropped
    busWrite(0, 12'h105, 0, 32'h01);
    expectRead("R11 byte set-enable", 0, 12'h104, 2, 32'hAAAAABAA);
    busWrite(0, 12'h106, 0, 32'h0000FF01);
    expectRead("R11 lane masking", 0, 12'h104, 2, 32'hAAABABAA);

    // R12 unmapped
    busWrite(0, 12'h900, 2, 32'hFFFFFFFF);
    expectRead("R12 unmapped read", 0, 12'h900, 2, 32'h0);
    busWrite(0, 12'h108, 2, 32'hFFFFFFFF);
    expectRead("R12 beyond lines", 0, 12'h108, 2, 32'h0);
    expectRead("R12 state unchanged", 0, 12'h104, 2, 32'hAAABABAA);
    expectPend("R12 flags unchanged", 32'h1);

    // R9 global line sweep over every target
    busWrite(0, 12'h144, 2, 32'hFFFFFFFF);
    busWrite(0, 12'h000, 2, 32'h1);
    expectPend("R10 enabled, nothing pending", 32'h0);
    for (int s = 0; s < 32; s++) begin
      busWrite(0, 12'h620 + 12'(s), 0, 32'd1 << (s % 4));
      busWrite(0, 12'h184, 2, 32'd1 << s);
      expectPend("R9 pending but disabled", 32'h0);
      busWrite(0, 12'h104, 2, 32'd1 << s);
      expectPend("R9 global line target", 32'd1 << (s % 4));
      busWrite(0, 12'h1C4, 2, 32'd1 << s);
      expectPend("R9 cleared", 32'h0);
      busWrite(0, 12'h144, 2, 32'd1 << s);
    end
    // R5 target naming an absent processor raises no flag
    busWrite(0, 12'h620, 0, 32'h10);
    busWrite(0, 12'h104, 2, 32'h1);
    busWrite(0, 12'h184, 2, 32'h1);
    expectPend("R5 absent target", 32'h0);
    busWrite(0, 12'h1C4, 2, 32'h1);

    // R9 / R3 private lines per processor
    for (int c = 0; c < NCPU; c++) begin
      busWrite(3'(c), 12'h180, 2, 32'h20);
      expectPend("R9 private sw line", 32'd1 << c);
      busWrite(3'(c), 12'h1C0, 2, 32'h20);
      busWrite(3'(c), 12'h180, 2, 32'h00100000);
      expectPend("R9 private line disabled", 32'h0);
      busWrite(3'(c), 12'h100, 2, 32'h00100000);
      expectPend("R3 private line enabled", 32'd1 << c);
      busWrite(3'(c), 12'h1C0, 2, 32'h00100000);
      busWrite(3'(c), 12'h140, 2, 32'h00100000);
    end

    // R10 global disable masks everything but processor 0
    busWrite(2, 12'h180, 2, 32'h20);
    expectPend("R9 cpu2 pending", 32'h4);
    busWrite(0, 12'h000, 2, 32'h0);
    expectPend("R10 disabled", 32'h1);
    expectRead("R10 ctrl readback", 0, 12'h000, 2, 32'h0);
    busWrite(0, 12'h000, 2, 32'h1);
    expectPend("R10 re-enabled", 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule